// File: doc/BRIEF.md
# Debounced Pin Interrupt Detector

This block watches a bank of already-synchronized input pins and raises per-pin event flags when a pin shows the trigger it has been set up for: a rising edge, a falling edge, either edge, a high level or a low level. A shared sampling strobe, derived either from the system clock or from an external slow tick input, can drive a two-sample glitch filter on any pin that has filtering turned on. Pins without filtering are evaluated on every system clock.

Firmware configures the block through a simple word-wide register port. Each register is written on a clock edge and read back combinationally. Event flags are cleared by writing ones to the flag register. The interrupt output is high whenever any flag is set. Each pin's filter is a four-state machine: `FLT_LOW`, `FLT_RISE_PEND`, `FLT_HIGH` and `FLT_FALL_PEND`. On every strobe, a sample of 1 moves `FLT_LOW` to `FLT_RISE_PEND`. From `FLT_RISE_PEND`, a second 1 moves to `FLT_HIGH` and a 0 returns to `FLT_LOW`. The path from `FLT_HIGH` through `FLT_FALL_PEND` is the mirror image. The filtered value is high in `FLT_HIGH` and in `FLT_FALL_PEND`.

Top module: `pin_event_irq`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0.
- R2: Register addresses are as follows. Address 0 is the trigger enable register: bit n arms falling/low detection and bit n+16 arms rising/high detection for pin n. Address 1 is the mode select, where bit n = 1 selects level mode and 0 selects edge mode. Address 2 is the filter enable. Address 3 is the control register: bits [3:0] hold the period exponent, bit 4 = 1 takes the slow tick as the source, and bit 5 = 1 keeps edge tracking always running. Address 4 holds the event flags. Bits that are not implemented, and addresses 5 to 7, read 0.
- R3: In edge mode, an unfiltered pin sets its flag on the clock edge at which the pin differs from its previous value in an armed direction. Arming both halves catches both edges. A change in a direction that is not armed sets nothing.
- R4: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A new event in the same cycle as the clear wins.
- R5: In level mode, the flag is set on every cycle while the armed level is present, so a clear during that level does not take effect.
- R6: `irq_o` is the OR of all flag bits.
- R7: The filter samples once every 2^exponent source events. Its output changes only after two consecutive samples agree, so a pulse shorter than one period never produces an event.
- R8: When the slow tick is selected, filtered pins advance only on slow tick pulses.
- R9: Pins with filtering off keep per-clock evaluation while other pins are filtered.
- R10: With always-run clear and neither enable set for a pin, that pin's history is frozen, so arming it after the pin has changed reports that change. With always-run set, the history keeps tracking and no such event appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 16 | Synchronized pin levels |
| slow_tick_i | input | 1 | Single-cycle pulse from the slow timebase |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `pins_i` and `slow_tick_i` are already synchronous to `clk`, and that a slow tick lasts a single cycle. Under those assumptions, flags only drop on writes and filtered values only move on strobes. The bench drives every input at the falling edge to stay within these limits. Its random phases keep filtering off so that a per-clock reference model can follow the flags exactly. The filtered and slow-tick behaviour is checked in directed runs, which sample only at points where every possible strobe phase gives the same answer.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADDR_ENA = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_LVL = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_DBE = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTL = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_STS = 3'd4;

    typedef enum logic [1:0] {
        FLT_LOW       = 2'd0,
        FLT_RISE_PEND = 2'd1,
        FLT_HIGH      = 2'd2,
        FLT_FALL_PEND = 2'd3
    } flt_state_e;
endpackage

// File: rtl/pin_evt_regs.sv
module pin_evt_regs
    import pin_evt_pkg::*;
#(
    parameter int unsigned NPIN = 16,
    parameter int unsigned SELW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [2*NPIN-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [2*NPIN-1:0]     rd_data,
    input  logic [NPIN-1:0]       evt,
    output logic [2*NPIN-1:0]     ena,
    output logic [NPIN-1:0]       lvl,
    output logic [NPIN-1:0]       dbe,
    output logic [SELW-1:0]       sel,
    output logic                  src_slow,
    output logic                  aon,
    output logic [NPIN-1:0]       sts
);
    localparam int unsigned DW   = 2 * NPIN;
    localparam int unsigned CTLW = SELW + 2;

    logic [DW-1:0]   ena_q;
    logic [NPIN-1:0] lvl_q;
    logic [NPIN-1:0] dbe_q;
    logic [CTLW-1:0] ctl_q;
    logic [NPIN-1:0] sts_q;
    logic [NPIN-1:0] clr;

    assign clr = (wr_en && wr_addr == ADDR_STS) ? wr_data[NPIN-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q <= '0;
            lvl_q <= '0;
            dbe_q <= '0;
            ctl_q <= '0;
            sts_q <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    ADDR_ENA: ena_q <= wr_data;
                    ADDR_LVL: lvl_q <= wr_data[NPIN-1:0];
                    ADDR_DBE: dbe_q <= wr_data[NPIN-1:0];
                    ADDR_CTL: ctl_q <= wr_data[CTLW-1:0];
                    default:  ;
                endcase
            end
            // new events take priority over a same-cycle clear
            sts_q <= (sts_q & ~clr) | evt;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_ENA: rd_data = ena_q;
            ADDR_LVL: rd_data = DW'(lvl_q);
            ADDR_DBE: rd_data = DW'(dbe_q);
            ADDR_CTL: rd_data = DW'(ctl_q);
            ADDR_STS: rd_data = DW'(sts_q);
            default:  rd_data = '0;
        endcase
    end

    assign ena      = ena_q;
    assign lvl      = lvl_q;
    assign dbe      = dbe_q;
    assign sel      = ctl_q[SELW-1:0];
    assign src_slow = ctl_q[SELW];
    assign aon      = ctl_q[SELW+1];
    assign sts      = sts_q;
endmodule

// File: rtl/pin_evt_strobe.sv
module pin_evt_strobe #(
    parameter int unsigned SELW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_slow,
    input  logic            slow_tick,
    input  logic [SELW-1:0] sel,
    output logic            stb
);
    localparam int unsigned CNTW = (1 << SELW) - 1;

    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] limit;
    logic            src_evt;

    // 2**sel - 1; the top code wraps to all ones, giving the longest period
    assign limit   = (CNTW'(1) << sel) - CNTW'(1);
    assign src_evt = src_slow ? slow_tick : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            stb   <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (src_evt) begin
                if (cnt_q >= limit) begin
                    cnt_q <= '0;
                    stb   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNTW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pin_evt_chan.sv
module pin_evt_chan
    import pin_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic use_db,
    input  logic stb,
    input  logic run,
    input  logic en_fall,
    input  logic en_rise,
    input  logic lvl_mode,
    output logic filt,
    output logic cur,
    output logic evt
);
    flt_state_e st_q;
    flt_state_e st_d;
    logic       prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLT_LOW;
        else        st_q <= st_d;
    end

    // transitions: two agreeing samples are needed to change the output
    always_comb begin
        st_d = st_q;
        if (run && stb) begin
            unique case (st_q)
                FLT_LOW:       if (pin) st_d = FLT_RISE_PEND;
                FLT_RISE_PEND: st_d = pin ? FLT_HIGH : FLT_LOW;
                FLT_HIGH:      if (!pin) st_d = FLT_FALL_PEND;
                FLT_FALL_PEND: st_d = pin ? FLT_HIGH : FLT_LOW;
            endcase
        end
    end

    // outputs
    always_comb begin
        filt = (st_q == FLT_HIGH) || (st_q == FLT_FALL_PEND);
        cur  = use_db ? filt : pin;
        if (lvl_mode)
            evt = (en_fall & ~cur) | (en_rise & cur);
        else
            evt = run & ((en_fall & prev_q & ~cur) | (en_rise & ~prev_q & cur));
    end

    // edge history only advances while the pin's detector runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   prev_q <= 1'b0;
        else if (run) prev_q <= cur;
    end
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
    import pin_evt_pkg::*;
#(
    parameter int unsigned NPIN = 16,
    parameter int unsigned SELW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPIN-1:0]     pins_i,
    input  logic                slow_tick_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [2*NPIN-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [2*NPIN-1:0]   rd_data_o,
    output logic                irq_o
);
    localparam int unsigned DW = 2 * NPIN;

    logic [DW-1:0]   ena_w;
    logic [NPIN-1:0] lvl_w;
    logic [NPIN-1:0] dbe_w;
    logic [SELW-1:0] sel_w;
    logic            src_w;
    logic            aon_w;
    logic [NPIN-1:0] sts_w;
    logic            stb_w;
    logic [NPIN-1:0] filt_w;
    logic [NPIN-1:0] cur_w;
    logic [NPIN-1:0] evt_w;

    pin_evt_regs #(.NPIN(NPIN), .SELW(SELW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .rd_addr  (rd_addr_i),
        .rd_data  (rd_data_o),
        .evt      (evt_w),
        .ena      (ena_w),
        .lvl      (lvl_w),
        .dbe      (dbe_w),
        .sel      (sel_w),
        .src_slow (src_w),
        .aon      (aon_w),
        .sts      (sts_w)
    );

    pin_evt_strobe #(.SELW(SELW)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_slow  (src_w),
        .slow_tick (slow_tick_i),
        .sel       (sel_w),
        .stb       (stb_w)
    );

    for (genvar n = 0; n < NPIN; n++) begin : g_chan
        pin_evt_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (pins_i[n]),
            .use_db   (dbe_w[n]),
            .stb      (stb_w),
            .run      (aon_w | ena_w[n] | ena_w[n+NPIN]),
            .en_fall  (ena_w[n]),
            .en_rise  (ena_w[n+NPIN]),
            .lvl_mode (lvl_w[n]),
            .filt     (filt_w[n]),
            .cur      (cur_w[n]),
            .evt      (evt_w[n])
        );
    end

    assign irq_o = |sts_w;
endmodule

// File: rtl/pin_event_irq_sva.sv
module pin_event_irq_sva
    import pin_evt_pkg::*;
#(
    parameter int unsigned NPIN = 16,
    parameter int unsigned SELW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [2*NPIN-1:0] ena,
    input logic [NPIN-1:0]   lvl,
    input logic [NPIN-1:0]   sts,
    input logic [NPIN-1:0]   cur,
    input logic [NPIN-1:0]   filt,
    input logic              stb,
    input logic              src_slow,
    input logic [SELW-1:0]   sel
);
    logic sts_wr;
    logic [NPIN-1:0] lvl_hit;
    assign sts_wr  = wr_en && (wr_addr == ADDR_STS);
    assign lvl_hit = lvl & ena[2*NPIN-1:NPIN] & cur;

    // R4: flags only drop on a clear write
    assert_set_bits_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr |=> ((sts & $past(sts)) == $past(sts)));

    // R3: nothing is flagged while no enable is set
    assert_quiet_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ena == '0 && !sts_wr) |=> $stable(sts));

    // R5: a present armed high level is flagged next cycle, clear or not
    assert_level_reassert_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts & $past(lvl_hit)) == $past(lvl_hit)));

    // R7: filter outputs move only after a strobe
    assert_filter_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(filt));

    // R8: system clock source with exponent 0 strobes every cycle
    assert_fast_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_slow && sel == '0) |=> stb);
endmodule

bind pin_event_irq pin_event_irq_sva #(.NPIN(NPIN), .SELW(SELW)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .wr_addr  (wr_addr_i),
    .ena      (ena_w),
    .lvl      (lvl_w),
    .sts      (sts_w),
    .cur      (cur_w),
    .filt     (filt_w),
    .stb      (stb_w),
    .src_slow (src_w),
    .sel      (sel_w)
);

// File: tb/pin_event_irq_tb.sv
module pin_event_irq_tb;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          slow = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [2:0]    rd_addr = 3'd4;
    logic [31:0]   rd_data;
    logic          irq;

    int  checks = 0;
    int  fails = 0;
    bit  model_on = 1'b0;
    bit  done = 1'b0;

    // reference state for unfiltered operation
    logic [31:0]   m_ena;
    logic [NP-1:0] m_lvl, m_sts, m_prev;
    logic          m_aon;

    always #4 clk = ~clk;

    pin_event_irq u_dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .slow_tick_i(slow),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    function automatic logic [NP-1:0] model_evt(input logic [NP-1:0] p);
        logic [NP-1:0] e;
        for (int n = 0; n < NP; n++) begin
            logic f, r, run;
            f   = m_ena[n];
            r   = m_ena[n+NP];
            run = m_aon | f | r;
            if (m_lvl[n]) e[n] = (f & ~p[n]) | (r & p[n]);
            else          e[n] = run & ((f & m_prev[n] & ~p[n]) | (r & ~m_prev[n] & p[n]));
        end
        return e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ena = '0; m_lvl = '0; m_sts = '0; m_prev = '0; m_aon = 1'b0;
        end else begin
            logic [NP-1:0] e, clr;
            e = model_evt(pins);
            clr = (wr_en && wr_addr == 3'd4) ? wr_data[NP-1:0] : '0;
            m_sts = (m_sts & ~clr) | e;
            for (int n = 0; n < NP; n++)
                if (m_aon | m_ena[n] | m_ena[n+NP]) m_prev[n] = pins[n];
            if (wr_en) begin
                if (wr_addr == 3'd0) m_ena = wr_data;
                if (wr_addr == 3'd1) m_lvl = wr_data[NP-1:0];
                if (wr_addr == 3'd3) m_aon = wr_data[5];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
        rd_addr = 3'd4;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pins = '0; slow = 1'b0; wr_en = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        int seed;
        seed = $urandom(32'd20240611);
        do_reset();

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reset read", d, 32'h0);
        end
        chk("R1 irq", {31'd0, irq}, 32'h0);

        // R2: register map and unused bits
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk("R2 enable", d, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); chk("R2 mode", d, 32'h0000_FFFF);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d); chk("R2 filter", d, 32'h0000_FFFF);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); chk("R2 control", d, 32'h0000_003F);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, d); chk("R2 flags not settable", d, 32'h0);
        rd(3'd7, d); chk("R2 unused address", d, 32'h0);

        // R3: rising on pin0, falling on pin1, both on pin2
        do_reset();
        wr(3'd0, 32'h0004_0006 | 32'h0001_0000);
        pins[0] = 1'b1; step(1); rd(3'd4, d); chk("R3 rising", d, 32'h1);
        pins[1] = 1'b1; step(1); rd(3'd4, d); chk("R3 unarmed rise", d, 32'h1);
        pins[1] = 1'b0; step(1); rd(3'd4, d); chk("R3 falling", d, 32'h3);
        wr(3'd4, 32'h3);
        pins[2] = 1'b1; step(1); rd(3'd4, d); chk("R3 both rise", d, 32'h4);
        wr(3'd4, 32'h4);
        pins[2] = 1'b0; step(1); rd(3'd4, d); chk("R3 both fall", d, 32'h4);

        // R4 / R6: write-one-to-clear and interrupt OR
        do_reset();
        wr(3'd0, 32'h0003_0000);
        pins[1:0] = 2'b11; step(2);
        rd(3'd4, d); chk("R4 two flags", d, 32'h3);
        wr(3'd4, 32'h0); rd(3'd4, d); chk("R4 zero write no effect", d, 32'h3);
        wr(3'd4, 32'h1); rd(3'd4, d); chk("R4 single clear", d, 32'h2);
        chk("R6 irq high", {31'd0, irq}, 32'h1);
        wr(3'd4, 32'h2); rd(3'd4, d); chk("R4 all clear", d, 32'h0);
        chk("R6 irq low", {31'd0, irq}, 32'h0);

        // R5: level re-asserts across a clear
        do_reset();
        wr(3'd1, 32'h4); wr(3'd0, 32'h0004_0000);
        pins[2] = 1'b1; step(2);
        rd(3'd4, d); chk("R5 level set", d, 32'h4);
        wr(3'd4, 32'h4); rd(3'd4, d); chk("R5 reassert after clear", d, 32'h4);
        pins[2] = 1'b0; step(1);
        wr(3'd4, 32'h4); rd(3'd4, d); chk("R5 clear once level gone", d, 32'h0);

        // R10: frozen history versus always-run
        do_reset();
        pins[3] = 1'b1; step(3);
        wr(3'd0, 32'h0008_0000); step(2);
        rd(3'd4, d); chk("R10 stale history reports change", d, 32'h8);
        do_reset();
        wr(3'd3, 32'h20);
        pins[3] = 1'b1; step(3);
        wr(3'd0, 32'h0008_0000); step(2);
        rd(3'd4, d); chk("R10 always-run no event", d, 32'h0);

        // R8: slow tick source, exponent 0
        do_reset();
        wr(3'd3, 32'h10); wr(3'd2, 32'h20); wr(3'd0, 32'h0020_0000);
        pins[5] = 1'b1; step(50);
        rd(3'd4, d); chk("R8 no tick no change", d, 32'h0);
        @(negedge clk); slow = 1'b1; @(negedge clk); slow = 1'b0; step(3);
        rd(3'd4, d); chk("R8 one sample not enough", d, 32'h0);
        @(negedge clk); slow = 1'b1; @(negedge clk); slow = 1'b0; step(3);
        rd(3'd4, d); chk("R8 two ticks", d, 32'h20);

        // R7 / R9: period 8 from the system clock on pin5, pin6 unfiltered
        do_reset();
        wr(3'd3, 32'h23); wr(3'd2, 32'h20); wr(3'd0, 32'h0060_0000);
        pins[5] = 1'b1; step(1); pins[5] = 1'b0; step(40);
        rd(3'd4, d); chk("R7 glitch rejected", d, 32'h0);
        pins[6] = 1'b1; step(1); pins[6] = 1'b0;
        rd(3'd4, d); chk("R9 unfiltered pin per clock", d, 32'h40);
        wr(3'd4, 32'h40);
        pins[5] = 1'b1; step(4);
        rd(3'd4, d); chk("R7 not before two samples", d, 32'h0);
        step(36);
        rd(3'd4, d); chk("R7 held pulse detected", d, 32'h20);

        // random phases against the model, filtering off
        do_reset();
        rd_addr = 3'd4;
        model_on = 1'b1;
        for (int ph = 0; ph < 4; ph++) begin
            wr(3'd0, $urandom);
            wr(3'd1, $urandom & $urandom & 32'hFFFF);
            wr(3'd3, {26'd0, 1'(ph[0]), 5'd0});
            for (int c = 0; c < 600; c++) begin
                @(negedge clk);
                wr_en = 1'b0;
                chk("R3/R5 random flags", rd_data, {16'd0, m_sts});
                chk("R6 random irq", {31'd0, irq}, {31'd0, |m_sts});
                pins = pins ^ NP'($urandom & $urandom);
                if ($urandom % 8 == 0) begin
                    wr_en = 1'b1; wr_addr = 3'd4; wr_data = $urandom;
                end
            end
            @(negedge clk); wr_en = 1'b0;
        end
        model_on = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule